// File: doc/BRIEF.md
# Shift and Rotate-Through-Carry Unit

This block performs single-position shifts and rotates on a byte and keeps a carry flag beside it. One strobe starts one operation. The operand, the operation code and the incoming carry are sampled on that clock edge. The result and the N, Z, V and C flags appear one cycle later and stay there until the next operation completes.

The two rotates treat the carry as a ninth bit. The bit that leaves the byte goes into C, and the carry that came in fills the vacated position. This lets software chain rotates across several bytes.

A parity mode reuses the same nine-bit rotate path. It rotates the byte and carry left nine times and counts the ones that pass through the carry during the first eight rotates. The ninth rotate puts the original byte and carry back in place. The unit then reports whether the byte held an odd or an even number of ones.

Top module: `bitshift_core`

## Requirements
- R1: Operation code 0 (arithmetic shift left) gives res = operand shifted left by one with bit 0 cleared, and C = the operand's bit 7.
- R2: Operation code 1 (arithmetic shift right) gives res = operand shifted right by one with bit 7 kept at its old value, and C = the operand's bit 0.
- R3: Operation code 2 (logical shift right) gives res = operand shifted right by one with bit 7 cleared, and C = the operand's bit 0.
- R4: Operation code 3 (rotate left through carry) gives res = {operand[6:0], cin}, and C = the operand's bit 7.
- R5: Operation code 4 (rotate right through carry) gives res = {cin, operand[7:1]}, and C = the operand's bit 0.
- R6: After every completed operation, N equals res bit 7 and Z is 1 exactly when res is zero.
- R7: After every completed operation, V equals N XOR C.
- R8: For codes 0 to 4, res, the flags and a one-cycle done pulse appear on the clock edge after the start edge. The outputs then hold until the next operation ends.
- R9: Operation code 5 (parity) raises busy on the start edge and keeps it high for nine rotate edges. On the ninth rotate edge, busy falls and done pulses. The parity output is 1 when the operand has an odd number of ones and 0 when the count is even.
- R10: When parity mode ends, res equals the original operand and C equals the original cin. N, Z and V follow R6 and R7.
- R11: A start strobe while busy is high is ignored. The parity run finishes with its own result and timing.
- R12: Operation codes 6 and 7 are ignored. No done pulse follows, and res and the flags keep their values.
- R13: After reset, res, all flags, parity, busy and done are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins an operation when the unit is idle |
| op | input | 3 | Operation code (0 to 5 are valid) |
| opnd | input | 8 | Operand byte |
| cin | input | 1 | Incoming carry |
| res | output | 8 | Result byte |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag, N XOR C |
| flag_c | output | 1 | Carry flag |
| parity | output | 1 | 1 when the last parity run counted an odd number of ones |
| busy | output | 1 | High while a parity run is in progress |
| done | output | 1 | One-cycle pulse when an operation completes |

## Verification
The assertions check the following on every cycle:
- the V and Z flag rules;
- the one-cycle latency of the single operations;
- the carry and fill bits of the left shift and the right rotate;
- the exact end of a parity run;
- that a start during a run is ignored;
- that the two unused codes are ignored.

Only the bench's scenarios can show some behaviours. These are the full result bytes for every operation and the parity value for bytes with odd and even counts. They also include the return of the original operand and carry after nine rotates, and that a start during a run leaves the run's result unchanged.

// File: rtl/bitshift_core.sv
module bitshift_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [2:0]   op,
  input  logic [W-1:0] opnd,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         flag_n,
  output logic         flag_z,
  output logic         flag_v,
  output logic         flag_c,
  output logic         parity,
  output logic         busy,
  output logic         done
);
  localparam int CW = $clog2(W + 1) + 1;
  localparam logic [CW-1:0] LAST = CW'(W);

  logic [W-1:0]  nres, rot_r;
  logic          nc, rot_c, ones;
  logic [CW-1:0] step;

  always_comb begin
    nres = opnd;
    nc   = cin;
    case (op)
      3'd0: begin nres = {opnd[W-2:0], 1'b0};     nc = opnd[W-1]; end
      3'd1: begin nres = {opnd[W-1], opnd[W-1:1]}; nc = opnd[0];   end
      3'd2: begin nres = {1'b0, opnd[W-1:1]};      nc = opnd[0];   end
      3'd3: begin nres = {opnd[W-2:0], cin};       nc = opnd[W-1]; end
      3'd4: begin nres = {cin, opnd[W-1:1]};       nc = opnd[0];   end
      default: ;
    endcase
  end

  assign rot_r = {res[W-2:0], flag_c};
  assign rot_c = res[W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res    <= '0;
      flag_n <= 1'b0;
      flag_z <= 1'b0;
      flag_v <= 1'b0;
      flag_c <= 1'b0;
      parity <= 1'b0;
      busy   <= 1'b0;
      done   <= 1'b0;
      ones   <= 1'b0;
      step   <= '0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        res    <= rot_r;
        flag_c <= rot_c;
        step   <= step + 1'b1;
        if (step != LAST) ones <= ones ^ rot_c;
        else begin
          busy   <= 1'b0;
          done   <= 1'b1;
          parity <= ones;
          flag_n <= rot_r[W-1];
          flag_z <= (rot_r == '0);
          flag_v <= rot_r[W-1] ^ rot_c;
        end
      end else if (start) begin
        if (op == 3'd5) begin
          busy   <= 1'b1;
          step   <= '0;
          ones   <= 1'b0;
          res    <= opnd;
          flag_c <= cin;
        end else if (op <= 3'd4) begin
          res    <= nres;
          flag_c <= nc;
          flag_n <= nres[W-1];
          flag_z <= (nres == '0);
          flag_v <= nres[W-1] ^ nc;
          done   <= 1'b1;
        end
      end
    end
  end

  AST_ASL_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && op == 3'd0 |=> flag_c == $past(opnd[W-1]) && res[0] == 1'b0); // R1
  AST_ROR_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && op == 3'd4 |=> res[W-1] == $past(cin) && flag_c == $past(opnd[0])); // R5
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> flag_z == (res == '0)); // R6
  AST_V_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> flag_v == (flag_n ^ flag_c)); // R7
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && op <= 3'd4 |=> done && !busy); // R8
  AST_RUN_END: assert property (@(posedge clk) disable iff (!rst_n)
    busy && step == LAST |=> done && !busy); // R9
  AST_RUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && step != LAST |=> busy && !done); // R11
  AST_BAD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && op > 3'd5 |=> !done && $stable(res)); // R12
endmodule

// File: tb/sim_bitshift_core.sv
module sim_bitshift_core;
  logic       clk = 1'b0;
  logic       rst_n, start, cin;
  logic [2:0] op;
  logic [7:0] opnd, res;
  logic       flag_n, flag_z, flag_v, flag_c, parity, busy, done;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  bitshift_core #(.W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .opnd(opnd), .cin(cin),
    .res(res), .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c),
    .parity(parity), .busy(busy), .done(done)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_flags(input string tag, input logic [7:0] r, input logic c);
    chk({tag, " R6 N"}, flag_n, r[7]);
    chk({tag, " R6 Z"}, flag_z, r == 8'h00);
    chk({tag, " R7 V"}, flag_v, r[7] ^ c);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0; op = 3'd0; opnd = 8'h00; cin = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R13 res", res, 0);
    chk("R13 flags", {flag_n, flag_z, flag_v, flag_c}, 0);
    chk("R13 parity/busy/done", {parity, busy, done}, 0);
  endtask

  task automatic t_single(input string tag, input logic [2:0] code,
                          input logic [7:0] a, input logic c);
    logic [7:0] er;
    logic       ec;
    case (code)
      3'd0: begin er = {a[6:0], 1'b0}; ec = a[7]; end
      3'd1: begin er = {a[7], a[7:1]}; ec = a[0]; end
      3'd2: begin er = {1'b0, a[7:1]}; ec = a[0]; end
      3'd3: begin er = {a[6:0], c};    ec = a[7]; end
      default: begin er = {c, a[7:1]}; ec = a[0]; end
    endcase
    op = code; opnd = a; cin = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({tag, " R8 done"}, done, 1);
    chk({tag, " res"}, res, er);
    chk({tag, " C"}, flag_c, ec);
    check_flags(tag, er, ec);
    opnd = ~a; cin = ~c;
    @(negedge clk);
    chk({tag, " R8 done pulse"}, done, 0);
    chk({tag, " R8 hold"}, {res, flag_c}, {er, ec});
  endtask

  task automatic t_parity(input string tag, input logic [7:0] a, input logic c,
                          input bit disturb);
    op = 3'd5; opnd = a; cin = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({tag, " R9 busy rise"}, {busy, done}, 2'b10);
    for (int i = 2; i <= 9; i++) begin
      if (disturb && i == 3) begin op = 3'd0; opnd = 8'hFF; start = 1'b1; end
      else start = 1'b0;
      @(negedge clk);
      if (busy !== 1'b1 || done !== 1'b0) chk({tag, " R9 R11 busy hold"}, {busy, done}, 2'b10);
    end
    start = 1'b0;
    checks++;
    @(negedge clk);
    chk({tag, " R9 end"}, {busy, done}, 2'b01);
    chk({tag, " R9 parity"}, parity, ^a);
    chk({tag, " R10 res"}, res, a);
    chk({tag, " R10 C"}, flag_c, c);
    check_flags({tag, " R10"}, a, c);
    @(negedge clk);
    chk({tag, " R9 done pulse"}, done, 0);
  endtask

  task automatic t_badcode(input logic [2:0] code);
    logic [7:0] r0;
    logic [3:0] f0;
    r0 = res; f0 = {flag_n, flag_z, flag_v, flag_c};
    op = code; opnd = ~r0; cin = ~f0[0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R12 no done", done, 0);
    chk("R12 res kept", res, r0);
    chk("R12 flags kept", {flag_n, flag_z, flag_v, flag_c}, f0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_single("R1 asl", 3'd0, 8'hC3, 1'b0);
    t_single("R1 asl zero", 3'd0, 8'h80, 1'b1);
    t_single("R2 asr neg", 3'd1, 8'h85, 1'b0);
    t_single("R2 asr pos", 3'd1, 8'h42, 1'b1);
    t_single("R3 lsr", 3'd2, 8'hF1, 1'b1);
    t_single("R3 lsr zero", 3'd2, 8'h01, 1'b0);
    t_single("R4 rol c1", 3'd3, 8'h5A, 1'b1);
    t_single("R4 rol c0", 3'd3, 8'hA5, 1'b0);
    t_single("R5 ror c1", 3'd4, 8'h3C, 1'b1);
    t_single("R5 ror c0", 3'd4, 8'h01, 1'b0);
    t_badcode(3'd6);
    t_badcode(3'd7);
    t_parity("R9 odd", 8'hB5, 1'b1, 1'b0);
    t_parity("R9 even", 8'h96, 1'b0, 1'b0);
    t_parity("R9 zero", 8'h00, 1'b1, 1'b0);
    t_parity("R11 disturbed", 8'h07, 1'b0, 1'b1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule